// File: doc/BRIEF.md
# Half-Width Multiply-Accumulate Datapath

This block forms full 32x32-bit products for multi-precision product-scanning multiplication while owning only a 32x16-bit multiplier. An operand word A is held in a 32-bit register. An operand word B enters a 48-bit shift register that moves it down by 16 bits per step, so its low half and then its high half reach the multiplier in two consecutive cycles. The two partial products are added into a 68-bit accumulator, the second one weighted by 2^16. Both operands come from a memory read bus through load strobes.

When a column of the product is complete, a shift command moves the accumulator down by one 32-bit word. The word that drops out is placed in a write-back register and flagged valid until the downstream store acknowledges it. Operand loads for the next product overlap with the multiply of the current one, so a new multiply-accumulate can start every second cycle. Address sequencing and modular reduction belong to the surrounding controller.

Top module: `half_mac_dp`

## Requirements
- R1: After reset wr_valid_o is 0 and the accumulator holds zero, so a first shift delivers the word 0.
- R2: Load B with load_b_i in cycle t, load A with load_a_i in cycle t+1 and pulse mac_start_i in cycle t+2 (MUL1, low half of B). Cycle t+3 is MUL2 (high half of B). The accumulator then has grown by the full product A*B.
- R3: Products from several multiply-accumulates without a shift add up in the accumulator, and carries propagate into the higher words.
- R4: A shift moves the accumulator right by 32 bits. The word shifted out is the sum after any partial product added in the same cycle. It appears on wr_data_o one cycle later.
- R5: With mac_start_i every second cycle, and B and A for the next product loaded in the MUL1 and MUL2 cycles of the current one, every product is accumulated exactly once.
- R6: Accumulation wraps modulo 2^68.
- R7: clear_i zeroes the accumulator and wr_valid_o in the next cycle, and takes priority over any add or shift in that cycle.
- R8: wr_valid_o rises after a shift and stays high until wr_ack_i is sampled high. wr_data_o changes only on a shift.
- R9: A shift_i pulse without mac_start_i shifts at once. A shift_i pulse given together with mac_start_i is carried out in the following MUL2 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Zero accumulator and write-valid flag |
| rd_data_i | input | 32 | Memory read bus word |
| load_a_i | input | 1 | Capture rd_data_i into operand A |
| load_b_i | input | 1 | Capture rd_data_i into top of operand B register |
| mac_start_i | input | 1 | Start a multiply-accumulate (MUL1 this cycle) |
| shift_i | input | 1 | Shift the accumulator one word down |
| wr_ack_i | input | 1 | Downstream store has taken the write word |
| wr_data_o | output | 32 | Word shifted out of the accumulator |
| wr_valid_o | output | 1 | wr_data_o holds a word not yet acknowledged |

## Verification
The hardest situation to reach is the fully overlapped schedule. In it the B register is loaded with the next word while it shifts the current high half down, and operand A is replaced in the same cycle that the multiplier still uses it for MUL2. The stimulus reaches it by issuing three products back to back, with every load placed in the MUL1 or MUL2 cycle of the product before it, and then draining the accumulator word by word. Wrap-around is reached by accumulating seventeen all-ones products, which carries past bit 67.

// File: rtl/half_mac_pkg.sv
package half_mac_pkg;
  typedef struct packed {
    logic add_lo;   // MUL1: add A*B[15:0]
    logic add_hi;   // MUL2: add A*B[31:16] << 16
    logic shift;    // shift accumulator one word
    logic shift_b;  // move operand B register down one half
  } mac_ctrl_t;
endpackage

// File: rtl/half_mac_ctrl.sv
module half_mac_ctrl
  import half_mac_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_b_i,
  input  logic      mac_start_i,
  input  logic      shift_i,
  output mac_ctrl_t ctrl_o
);
  logic b_sh_q, mul2_q, mul2_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_sh_q    <= 1'b0;
      mul2_q    <= 1'b0;
      mul2_sh_q <= 1'b0;
    end else begin
      b_sh_q    <= load_b_i;
      mul2_q    <= mac_start_i;
      mul2_sh_q <= mac_start_i & shift_i;
    end
  end

  always_comb begin
    ctrl_o.add_lo  = mac_start_i;
    ctrl_o.add_hi  = mul2_q;
    ctrl_o.shift   = mul2_sh_q | (shift_i & ~mac_start_i);
    ctrl_o.shift_b = b_sh_q | mac_start_i;
  end
endmodule

// File: rtl/half_mac_operands.sv
module half_mac_operands #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned OPB_W  = WORD_W + HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] rd_data_i,
  input  logic              load_a_i,
  input  logic              load_b_i,
  input  logic              shift_b_i,
  output logic [WORD_W-1:0] opa_o,
  output logic [HALF_W-1:0] opb_half_o
);
  logic [WORD_W-1:0] opa_q;
  logic [OPB_W-1:0]  opb_q, opb_base, opb_d;

  always_comb begin
    opb_base = shift_b_i ? (opb_q >> HALF_W) : opb_q;
    opb_d    = load_b_i ? {rd_data_i, opb_base[HALF_W-1:0]} : opb_base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opa_q <= '0;
      opb_q <= '0;
    end else begin
      if (load_a_i) opa_q <= rd_data_i;
      opb_q <= opb_d;
    end
  end

  assign opa_o      = opa_q;
  assign opb_half_o = opb_q[HALF_W-1:0];
endmodule

// File: rtl/half_mac_mul.sv
module half_mac_mul #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ACC_W  = 68,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned PROD_W = WORD_W + HALF_W
) (
  input  logic [WORD_W-1:0] opa_i,
  input  logic [HALF_W-1:0] opb_half_i,
  input  logic              add_lo_i,
  input  logic              add_hi_i,
  output logic [ACC_W-1:0]  addend_o
);
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  prod_ext;

  always_comb begin
    prod     = PROD_W'(opa_i) * PROD_W'(opb_half_i);
    prod_ext = ACC_W'(prod);
    if (add_hi_i)      addend_o = prod_ext << HALF_W;
    else if (add_lo_i) addend_o = prod_ext;
    else               addend_o = '0;
  end
endmodule

// File: rtl/half_mac_acc.sv
module half_mac_acc #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ACC_W  = 68
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [ACC_W-1:0]  addend_i,
  input  logic              shift_i,
  input  logic              wr_ack_i,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              wr_valid_o
);
  logic [ACC_W-1:0]  acc_q, sum;
  logic [WORD_W-1:0] wr_q;
  logic              valid_q;

  assign sum = acc_q + addend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      wr_q    <= '0;
      valid_q <= 1'b0;
    end else if (clear_i) begin
      acc_q   <= '0;
      valid_q <= 1'b0;
    end else if (shift_i) begin
      acc_q   <= sum >> WORD_W;
      wr_q    <= sum[WORD_W-1:0];
      valid_q <= 1'b1;
    end else begin
      acc_q <= sum;
      if (wr_ack_i) valid_q <= 1'b0;
    end
  end

  assign wr_data_o  = wr_q;
  assign wr_valid_o = valid_q;
endmodule

// File: rtl/half_mac_dp.sv
module half_mac_dp
  import half_mac_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned GUARD_W = 4,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned ACC_W  = 2 * WORD_W + GUARD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [WORD_W-1:0] rd_data_i,
  input  logic              load_a_i,
  input  logic              load_b_i,
  input  logic              mac_start_i,
  input  logic              shift_i,
  input  logic              wr_ack_i,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              wr_valid_o
);
  mac_ctrl_t         ctrl;
  logic [WORD_W-1:0] opa;
  logic [HALF_W-1:0] opb_half;
  logic [ACC_W-1:0]  addend;

  half_mac_ctrl i_ctrl (
    .clk_i, .rst_ni, .load_b_i, .mac_start_i, .shift_i, .ctrl_o(ctrl)
  );

  half_mac_operands #(.WORD_W(WORD_W)) i_ops (
    .clk_i, .rst_ni, .rd_data_i, .load_a_i, .load_b_i,
    .shift_b_i(ctrl.shift_b), .opa_o(opa), .opb_half_o(opb_half)
  );

  half_mac_mul #(.WORD_W(WORD_W), .ACC_W(ACC_W)) i_mul (
    .opa_i(opa), .opb_half_i(opb_half),
    .add_lo_i(ctrl.add_lo), .add_hi_i(ctrl.add_hi), .addend_o(addend)
  );

  half_mac_acc #(.WORD_W(WORD_W), .ACC_W(ACC_W)) i_acc (
    .clk_i, .rst_ni, .clear_i, .addend_i(addend), .shift_i(ctrl.shift),
    .wr_ack_i, .wr_data_o, .wr_valid_o
  );
endmodule

// File: rtl/half_mac_chk.sv
module half_mac_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              mac_start_i,
  input logic              wr_ack_i,
  input logic              wr_valid_o,
  input logic [WORD_W-1:0] wr_data_o,
  input logic              do_shift,
  input logic              mul2
);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !wr_valid_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ack_i && !clear_i |=> wr_valid_o);

  p_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && wr_ack_i && !do_shift && !clear_i |=> !wr_valid_o);

  p_data_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !do_shift |=> $stable(wr_data_o));

  p_shift_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_shift && !clear_i |=> wr_valid_o);

  p_mul2_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_start_i |=> mul2);

  p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul2 |-> !mac_start_i);
endmodule

bind half_mac_dp half_mac_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_i, .rst_ni, .clear_i, .mac_start_i, .wr_ack_i, .wr_valid_o, .wr_data_o,
  .do_shift(ctrl.shift), .mul2(ctrl.add_hi)
);

// File: tb/test_half_mac_dp.sv
module test_half_mac_dp;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        clear_i = 0, load_a_i = 0, load_b_i = 0, mac_start_i = 0;
  logic        shift_i = 0, wr_ack_i = 0;
  logic [31:0] rd_data_i = '0;
  logic [31:0] wr_data_o;
  logic        wr_valid_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [67:0] ref_acc = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  half_mac_dp i_half_mac_dp (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mac_one(input logic [31:0] a, input logic [31:0] b, input bit sh);
    logic [67:0] tmp;
    @(negedge clk_i); load_b_i = 1; rd_data_i = b;
    @(negedge clk_i); load_b_i = 0; load_a_i = 1; rd_data_i = a;
    @(negedge clk_i); load_a_i = 0; mac_start_i = 1; shift_i = sh;
    @(negedge clk_i); mac_start_i = 0; shift_i = 0;
    @(negedge clk_i);
    ref_acc = ref_acc + 68'(64'(a) * 64'(b));
    if (sh) begin
      tmp = ref_acc;
      chk("R2 word after mac+shift", wr_data_o, tmp[31:0]);
      chk("R9 valid after deferred shift", 32'(wr_valid_o), 32'd1);
      ref_acc = ref_acc >> 32;
    end
  endtask

  task automatic shift_word(input string req, output logic [31:0] got);
    @(negedge clk_i); shift_i = 1;
    @(negedge clk_i); shift_i = 0;
    got = wr_data_o;
    chk(req, got, ref_acc[31:0]);
    ref_acc = ref_acc >> 32;
  endtask

  task automatic do_clear();
    @(negedge clk_i); clear_i = 1;
    @(negedge clk_i); clear_i = 0;
    ref_acc = '0;
  endtask

  task automatic t_reset();
    logic [31:0] w;
    chk("R1 valid at reset", 32'(wr_valid_o), 32'd0);
    shift_word("R1 R9 idle shift of reset accumulator", w);
  endtask

  task automatic t_single();
    logic [31:0] w;
    do_clear();
    // B halves differ so the 2^16 weighting of MUL2 is visible
    mac_one(32'hDEAD_BEEF, 32'h1234_5678, 1'b1);
    shift_word("R4 high word of product", w);
    shift_word("R4 accumulator empty after two shifts", w);
  endtask

  task automatic t_accum();
    logic [31:0] w;
    do_clear();
    mac_one(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    mac_one(32'h8000_0001, 32'hC000_0003, 1'b0);
    mac_one(32'h0001_0000, 32'h0000_FFFF, 1'b0);
    shift_word("R3 column word 0", w);
    shift_word("R3 column word 1", w);
    shift_word("R3 carry word 2", w);
  endtask

  task automatic t_pipe();
    logic [31:0] a[3], b[3];
    logic [31:0] w;
    a = '{32'hA5A5_1234, 32'h0F0F_F0F0, 32'hFFFF_0001};
    b = '{32'h9876_FEDC, 32'hFFFF_FFFF, 32'h0001_8000};
    do_clear();
    @(negedge clk_i); load_b_i = 1; rd_data_i = b[0];
    @(negedge clk_i); load_b_i = 0; load_a_i = 1; rd_data_i = a[0];
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i); load_a_i = 0; mac_start_i = 1;
      if (i < 2) begin load_b_i = 1; rd_data_i = b[i+1]; end
      @(negedge clk_i); mac_start_i = 0; load_b_i = 0;
      if (i < 2) begin load_a_i = 1; rd_data_i = a[i+1]; end
      ref_acc = ref_acc + 68'(64'(a[i]) * 64'(b[i]));
    end
    @(negedge clk_i); load_a_i = 0;
    shift_word("R5 pipelined word 0", w);
    shift_word("R5 pipelined word 1", w);
    shift_word("R5 pipelined word 2", w);
  endtask

  task automatic t_wrap();
    logic [31:0] w;
    do_clear();
    for (int i = 0; i < 17; i++) mac_one(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    shift_word("R6 wrapped word 0", w);
    shift_word("R6 wrapped word 1", w);
    // 17*(2^32-1)^2 exceeds 2^68: bits 67:64 wrap to zero
    shift_word("R6 top bits after wrap", w);
    chk("R6 top bits explicit", w, 32'd0);
  endtask

  task automatic t_clear();
    logic [31:0] w;
    do_clear();
    mac_one(32'h1357_9BDF, 32'h2468_ACE0, 1'b1);
    mac_one(32'h1111_1111, 32'h2222_2222, 1'b0);
    do_clear();
    chk("R7 valid after clear", 32'(wr_valid_o), 32'd0);
    shift_word("R7 accumulator zero after clear", w);
  endtask

  task automatic t_handshake();
    logic [31:0] w, held;
    do_clear();
    mac_one(32'h0000_0005, 32'h0000_0007, 1'b0);
    shift_word("R8 word before handshake", w);
    held = w;
    chk("R8 valid raised", 32'(wr_valid_o), 32'd1);
    repeat (3) @(negedge clk_i);
    chk("R8 valid held without ack", 32'(wr_valid_o), 32'd1);
    chk("R8 data held without shift", wr_data_o, held);
    @(negedge clk_i); wr_ack_i = 1;
    @(negedge clk_i); wr_ack_i = 0;
    chk("R8 valid dropped on ack", 32'(wr_valid_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_accum();
    t_pipe();
    t_wrap();
    t_clear();
    t_handshake();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule